// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block picks, each instruction cycle, one request from sixteen interrupt sources. Every source has a small control register that holds a pending flag, an enable, a four-bit priority level and a two-bit group rank. A request can compete only when its level is strictly above the level of the routine the CPU is running and the global enable is set. Among the requests that can compete, the highest level wins. When two have the same level, the higher group rank wins.

A winner at one of the two top levels (14 or 15) is normally sent to a data-transfer channel rather than to the CPU. The channel number is made from the low bit of the level and the two group bits. If that channel reports an exhausted count, the request goes to the CPU as an ordinary interrupt instead. A consumer-side `ack` input marks the cycles in which a service may be issued. In such a cycle the block pulses either a CPU take, with the source index and the previous CPU level, or a channel request, with the channel number. On a CPU take the CPU level register loads the winner's level. Saving state, fetching vectors and moving data are left to neighbouring logic.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset every control register reads zero, the global enable is 0, the CPU level is 0, and no take, channel request or clash is signalled.
- R2: A control register reads back as bit 7 pending flag, bit 6 enable, bits 5:2 level, bits 1:0 group. A software write replaces all fields, and setting or clearing the pending flag this way acts exactly like the hardware doing it.
- R3: A high `src_evt[i]` sets the pending flag of source i at the next clock edge.
- R4: A source competes only if it is pending, it is enabled, the global enable is 1, and its level is strictly greater than the CPU level. A source at level 0 never competes.
- R5: Among competing sources the higher level wins. At equal level the higher group value wins, with 3 highest.
- R6: When two competing sources have equal level and group, the lower index wins. `cfg_clash` is high whenever any two enabled sources have identical level and group.
- R7: A winner at level 14 or 15 whose channel {level[0], group[1:0]} has `chan_cnt_zero` low is issued as `chan_req`, with that channel number and source index.
- R8: A winner at level 14 or 15 whose channel has `chan_cnt_zero` high is issued as a CPU take at its own level.
- R9: `cpu_irq_take` and `chan_req` are high only in cycles where `ack` is high and a winner exists. They are never high together.
- R10: During a CPU take, `cpu_prev_lvl` shows the old CPU level. At the next edge the CPU level becomes the winner's level and the winner's pending flag clears.
- R11: A channel service clears the winner's pending flag, unless `chan_last` of that channel is high, in which case the flag stays set.
- R12: If a source event arrives in the same cycle as a service clear, the flag stays set. A software write to that register in the same cycle overrides both.
- R13: A status write loads the global enable and the CPU level, and it takes precedence over the level load of a CPU take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | 16 | Per-source request events |
| ctl_we | input | 1 | Control register write strobe |
| ctl_sel | input | 4 | Control register written |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rd_sel | input | 4 | Control register read back |
| ctl_rd_data | output | 8 | Read-back data |
| stat_we | input | 1 | Status (global enable, CPU level) write strobe |
| stat_gen | input | 1 | Global enable write value |
| stat_lvl | input | 4 | CPU level write value |
| glb_en | output | 1 | Current global enable |
| cpu_lvl | output | 4 | Current CPU level |
| chan_cnt_zero | input | 8 | Per channel: transfer count is zero |
| chan_last | input | 8 | Per channel: next transfer takes the count to zero |
| ack | input | 1 | Consumer can accept a service this cycle |
| cpu_irq_take | output | 1 | CPU interrupt entry pulse |
| cpu_src | output | 4 | Winning source for CPU entry |
| cpu_prev_lvl | output | 4 | CPU level before entry, for saving |
| chan_req | output | 1 | Channel service pulse |
| chan_num | output | 3 | Channel serviced |
| chan_src | output | 4 | Source serviced by the channel |
| cfg_clash | output | 1 | Two enabled sources share level and group |

## Verification
A wrong pending flag or CPU level shows up at the ports in the very next cycle that has `ack` high. The effect is a wrong winner index, a take where a channel request was due, or a missing or duplicate service. A corrupt register field can also be read back directly on `ctl_rd_data` on the following cycle. The bench runs a behavioural model alongside the design and compares every output on every clock. A divergence is therefore reported in the first cycle in which it becomes visible, rather than at the end of a scenario.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W  = 4;
  localparam int GRP_W  = 2;
  localparam int KEY_W  = LVL_W + GRP_W;
  localparam int CH_W   = 1 + GRP_W;
  localparam int N_CH   = 1 << CH_W;
  localparam int CTL_W  = 2 + KEY_W;

  typedef struct packed {
    logic             pend;
    logic             en;
    logic [LVL_W-1:0] lvl;
    logic [GRP_W-1:0] grp;
  } irq_ctl_t;
endpackage

// File: rtl/irq_ctl_bank.sv
module irq_ctl_bank
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            src_evt,
  input  logic                        ctl_we,
  input  logic [SRC_W-1:0]            ctl_sel,
  input  logic [CTL_W-1:0]            ctl_wdata,
  input  logic [N_SRC-1:0]            svc_clr,
  input  logic                        gen,
  input  logic [LVL_W-1:0]            cur_lvl,
  input  logic [SRC_W-1:0]            rd_sel,
  output logic [CTL_W-1:0]            rd_data,
  output logic [N_SRC-1:0]            elig,
  output logic [N_SRC-1:0]            en_vec,
  output logic [N_SRC-1:0][KEY_W-1:0] key_vec
);
  irq_ctl_t ctl_q [N_SRC];
  irq_ctl_t ctl_d [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic wr_hit;
    assign wr_hit = ctl_we && (ctl_sel == SRC_W'(i));

    always_comb begin
      ctl_d[i] = ctl_q[i];
      if (wr_hit) begin
        ctl_d[i] = irq_ctl_t'(ctl_wdata);
      end else if (src_evt[i]) begin
        ctl_d[i].pend = 1'b1;
      end else if (svc_clr[i]) begin
        ctl_d[i].pend = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[i] <= '0;
      end else begin
        ctl_q[i] <= ctl_d[i];
      end
    end

    assign elig[i]    = gen && ctl_q[i].pend && ctl_q[i].en && (ctl_q[i].lvl > cur_lvl);
    assign en_vec[i]  = ctl_q[i].en;
    assign key_vec[i] = {ctl_q[i].lvl, ctl_q[i].grp};

    // R3
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt[i] && !wr_hit) |=> ctl_q[i].pend);

    // R10
    clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_clr[i] && !src_evt[i] && !wr_hit) |=> !ctl_q[i].pend);
  end

  assign rd_data = CTL_W'(ctl_q[rd_sel]);
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int N_NODE = 2 * N_SRC - 1
) (
  input  logic [N_SRC-1:0]            elig,
  input  logic [N_SRC-1:0][KEY_W-1:0] key_vec,
  output logic                        win_vld,
  output logic [KEY_W-1:0]            win_key,
  output logic [SRC_W-1:0]            win_idx
);
  logic             nd_v [N_NODE];
  logic [KEY_W-1:0] nd_k [N_NODE];
  logic [SRC_W-1:0] nd_i [N_NODE];

  for (genvar l = 0; l < N_SRC; l++) begin : g_leaf
    assign nd_v[N_SRC-1+l] = elig[l];
    assign nd_k[N_SRC-1+l] = key_vec[l];
    assign nd_i[N_SRC-1+l] = SRC_W'(l);
  end

  for (genvar n = 0; n < N_SRC - 1; n++) begin : g_node
    logic take_left;
    assign take_left = nd_v[2*n+1] && (!nd_v[2*n+2] || (nd_k[2*n+1] >= nd_k[2*n+2]));
    assign nd_v[n] = nd_v[2*n+1] || nd_v[2*n+2];
    assign nd_k[n] = take_left ? nd_k[2*n+1] : nd_k[2*n+2];
    assign nd_i[n] = take_left ? nd_i[2*n+1] : nd_i[2*n+2];
  end

  assign win_vld = nd_v[0];
  assign win_key = nd_k[0];
  assign win_idx = nd_i[0];
endmodule

// File: rtl/irq_clash_detect.sv
module irq_clash_detect
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0]            en_vec,
  input  logic [N_SRC-1:0][KEY_W-1:0] key_vec,
  output logic                        clash
);
  always_comb begin
    clash = 1'b0;
    for (int a = 0; a < N_SRC; a++) begin
      for (int b = a + 1; b < N_SRC; b++) begin
        if (en_vec[a] && en_vec[b] && (key_vec[a] == key_vec[b])) begin
          clash = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              ctl_we,
  input  logic [SRC_W-1:0]  ctl_sel,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [SRC_W-1:0]  ctl_rd_sel,
  output logic [CTL_W-1:0]  ctl_rd_data,
  input  logic              stat_we,
  input  logic              stat_gen,
  input  logic [LVL_W-1:0]  stat_lvl,
  output logic              glb_en,
  output logic [LVL_W-1:0]  cpu_lvl,
  input  logic [N_CH-1:0]   chan_cnt_zero,
  input  logic [N_CH-1:0]   chan_last,
  input  logic              ack,
  output logic              cpu_irq_take,
  output logic [SRC_W-1:0]  cpu_src,
  output logic [LVL_W-1:0]  cpu_prev_lvl,
  output logic              chan_req,
  output logic [CH_W-1:0]   chan_num,
  output logic [SRC_W-1:0]  chan_src,
  output logic              cfg_clash
);
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic arst_n;
  assign arst_n = rst_s2_q;

  logic             gen_q, gen_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  logic [N_SRC-1:0]            elig, en_vec, svc_clr;
  logic [N_SRC-1:0][KEY_W-1:0] key_vec;
  logic                        win_vld;
  logic [KEY_W-1:0]            win_key;
  logic [SRC_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic [CH_W-1:0]             win_ch;
  logic                        top_band, to_chan, keep_pend;

  irq_ctl_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (arst_n),
    .src_evt  (src_evt),
    .ctl_we   (ctl_we),
    .ctl_sel  (ctl_sel),
    .ctl_wdata(ctl_wdata),
    .svc_clr  (svc_clr),
    .gen      (gen_q),
    .cur_lvl  (lvl_q),
    .rd_sel   (ctl_rd_sel),
    .rd_data  (ctl_rd_data),
    .elig     (elig),
    .en_vec   (en_vec),
    .key_vec  (key_vec)
  );

  irq_prio_tree #(.N_SRC(N_SRC)) u_tree (
    .elig   (elig),
    .key_vec(key_vec),
    .win_vld(win_vld),
    .win_key(win_key),
    .win_idx(win_idx)
  );

  irq_clash_detect #(.N_SRC(N_SRC)) u_clash (
    .en_vec (en_vec),
    .key_vec(key_vec),
    .clash  (cfg_clash)
  );

  assign win_lvl  = win_key[KEY_W-1:GRP_W];
  assign win_ch   = {win_lvl[0], win_key[GRP_W-1:0]};
  assign top_band = &win_lvl[LVL_W-1:1];
  assign to_chan  = top_band && !chan_cnt_zero[win_ch];

  assign cpu_irq_take = ack && win_vld && !to_chan;
  assign chan_req     = ack && win_vld && to_chan;
  assign cpu_src      = win_idx;
  assign chan_src     = win_idx;
  assign chan_num     = win_ch;
  assign cpu_prev_lvl = lvl_q;

  assign keep_pend = chan_req && chan_last[win_ch];
  always_comb begin
    svc_clr = '0;
    if ((cpu_irq_take || chan_req) && !keep_pend) begin
      svc_clr[win_idx] = 1'b1;
    end
  end

  always_comb begin
    gen_d = gen_q;
    lvl_d = lvl_q;
    if (stat_we) begin
      gen_d = stat_gen;
      lvl_d = stat_lvl;
    end else if (cpu_irq_take) begin
      lvl_d = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gen_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      gen_q <= gen_d;
      lvl_q <= lvl_d;
    end
  end

  assign glb_en  = gen_q;
  assign cpu_lvl = lvl_q;

  // R9
  no_dual_svc_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !(cpu_irq_take && chan_req));

  // R4
  take_above_lvl_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_irq_take || chan_req) |-> (gen_q && (win_lvl > lvl_q)));

  // R10
  lvl_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_irq_take && !stat_we) |=> (lvl_q == $past(win_lvl)));

  // R7
  chan_band_chk: assert property (@(posedge clk) disable iff (!arst_n)
    chan_req |-> (win_lvl >= LVL_W'(14)));

  // R10
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(svc_clr));
endmodule

// File: tb/prio_irq_arbiter_bench.sv
module prio_irq_arbiter_bench;
  localparam int N = 16;

  logic        clk, rst_n;
  logic [15:0] src_evt;
  logic        ctl_we;
  logic [3:0]  ctl_sel;
  logic [7:0]  ctl_wdata;
  logic [3:0]  ctl_rd_sel;
  logic [7:0]  ctl_rd_data;
  logic        stat_we, stat_gen;
  logic [3:0]  stat_lvl;
  logic        glb_en;
  logic [3:0]  cpu_lvl;
  logic [7:0]  chan_cnt_zero, chan_last;
  logic        ack;
  logic        cpu_irq_take, chan_req, cfg_clash;
  logic [3:0]  cpu_src, cpu_prev_lvl, chan_src;
  logic [2:0]  chan_num;

  prio_irq_arbiter u_prio_irq_arbiter (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit m_pend[N], m_en[N];
  int m_lvl[N], m_grp[N];
  bit m_gen;
  int m_cpu;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_and_advance();
    int best, bkey, ch, eb;
    bit route, etake, ereq, eclash;
    best = -1; bkey = -1;
    for (int i = 0; i < N; i++) begin
      if (m_gen && m_pend[i] && m_en[i] && (m_lvl[i] > m_cpu)) begin
        if (m_lvl[i] * 4 + m_grp[i] > bkey) begin
          bkey = m_lvl[i] * 4 + m_grp[i];
          best = i;
        end
      end
    end
    route = 0; ch = 0;
    if (best >= 0) begin
      ch = (m_lvl[best] % 2) * 4 + m_grp[best];
      route = (m_lvl[best] >= 14) && !chan_cnt_zero[ch];
    end
    etake = ack && (best >= 0) && !route;
    ereq  = ack && (best >= 0) && route;
    eclash = 0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (m_en[a] && m_en[b] && m_lvl[a] == m_lvl[b] && m_grp[a] == m_grp[b]) eclash = 1;

    // R2 R3 R11 R12: register contents seen on read-back
    eb = m_pend[ctl_rd_sel] * 128 + m_en[ctl_rd_sel] * 64 + m_lvl[ctl_rd_sel] * 4 + m_grp[ctl_rd_sel];
    chk(ctl_rd_data == eb, "R2/R3/R11/R12 ctl_rd_data", ctl_rd_data, eb);
    chk(glb_en == m_gen, "R13 glb_en", glb_en, m_gen);
    chk(cpu_lvl == m_cpu, "R10/R13 cpu_lvl", cpu_lvl, m_cpu);
    chk(cpu_irq_take == etake, "R4/R8/R9 cpu_irq_take", cpu_irq_take, etake);
    chk(chan_req == ereq, "R7/R9 chan_req", chan_req, ereq);
    chk(cfg_clash == eclash, "R6 cfg_clash", cfg_clash, eclash);
    if (etake) begin
      chk(cpu_src == best, "R5/R6 cpu_src", cpu_src, best);
      chk(cpu_prev_lvl == m_cpu, "R10 cpu_prev_lvl", cpu_prev_lvl, m_cpu);
    end
    if (ereq) begin
      chk(chan_src == best, "R5/R6 chan_src", chan_src, best);
      chk(chan_num == ch, "R7 chan_num", chan_num, ch);
    end

    for (int i = 0; i < N; i++) begin
      if (ctl_we && ctl_sel == i) begin
        m_pend[i] = ctl_wdata[7]; m_en[i] = ctl_wdata[6];
        m_lvl[i] = ctl_wdata[5:2]; m_grp[i] = ctl_wdata[1:0];
      end else if (src_evt[i]) begin
        m_pend[i] = 1;
      end else if (i == best && (etake || (ereq && !chan_last[ch]))) begin
        m_pend[i] = 0;
      end
    end
    if (stat_we) begin
      m_gen = stat_gen; m_cpu = stat_lvl;
    end else if (etake) begin
      m_cpu = m_lvl[best];
    end
  endtask

  task automatic idle_inputs();
    src_evt = '0; ctl_we = 0; ctl_sel = '0; ctl_wdata = '0;
    stat_we = 0; stat_gen = 0; stat_lvl = '0;
    chan_cnt_zero = '0; chan_last = '0; ack = 0;
  endtask

  task automatic run_cycle();
    #1;
    compare_and_advance();
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input bit p, input bit e, input int l, input int g);
    idle_inputs();
    ctl_we = 1; ctl_sel = sel[3:0];
    ctl_wdata = {p, e, l[3:0], g[1:0]};
    run_cycle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_grp[i] = 0;
    end
    m_gen = 0; m_cpu = 0;
    idle_inputs();
    ctl_rd_sel = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state of every register
    for (int i = 0; i < N; i++) begin
      ctl_rd_sel = i[3:0];
      ack = 1;
      run_cycle();
    end

    // Directed: R5 group order, R6 tie, R8 fallback, R12 event vs clear
    idle_inputs(); stat_we = 1; stat_gen = 1; stat_lvl = 0; run_cycle();
    wr(3, 1, 1, 5, 1);
    wr(7, 1, 1, 5, 2);
    wr(9, 1, 1, 5, 2);
    idle_inputs(); ctl_rd_sel = 7; ack = 1; src_evt[7] = 1; run_cycle();
    idle_inputs(); ctl_rd_sel = 7; run_cycle();
    wr(12, 1, 1, 15, 3);
    idle_inputs(); stat_we = 1; stat_gen = 1; stat_lvl = 0; run_cycle();
    idle_inputs(); chan_cnt_zero = 8'h80; ack = 1; ctl_rd_sel = 12; run_cycle();
    wr(12, 1, 1, 14, 1);
    idle_inputs(); chan_last = 8'h02; ack = 1; ctl_rd_sel = 12; run_cycle();
    idle_inputs(); ack = 1; ctl_rd_sel = 12; run_cycle();
    wr(0, 1, 1, 0, 3);
    idle_inputs(); ack = 1; ctl_rd_sel = 0; run_cycle();

    // Random phase, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      idle_inputs();
      src_evt = 16'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 5) == 0) begin
        ctl_we = 1; ctl_sel = 4'($urandom); ctl_wdata = 8'($urandom);
        if ($urandom_range(0, 1) == 1) ctl_wdata[5:3] = 3'b111;
      end
      if ($urandom_range(0, 23) == 0) begin
        stat_we = 1; stat_gen = ($urandom_range(0, 7) != 0);
        stat_lvl = 4'($urandom_range(0, 12));
      end
      chan_cnt_zero = 8'($urandom);
      chan_last = 8'($urandom);
      ack = $urandom_range(0, 1) == 1;
      ctl_rd_sel = 4'($urandom);
      run_cycle();
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule